// File: doc/BRIEF.md
# Four-Channel Triggered DMA Engine

This block moves data from memory to memory for up to four independent channels that share one request/grant memory port. Each channel holds a programmed source address, destination address, unit count and control word. When a channel's trigger arrives, the engine copies one 16-bit or 32-bit unit at a time: one read from the working source address, then one write of the same data to the working destination address. After each write it steps both working addresses according to that channel's address modes.

A channel can be triggered by its own enable edge, by a vertical-blank pulse, by a horizontal-blank pulse, or by a per-channel special request line. A single programming port writes one register per cycle. The engine re-arbitrates before every unit, so a lower-numbered channel always wins and can cut in between the units of a higher-numbered one. While a unit is in flight a busy output stays high so that the CPU can be stalled. When a channel finishes its count it can pulse its own interrupt line. It then either drops its enable bit, or, if it repeats, reloads its count and waits for the next trigger.

Top module: `dma4_engine`

## Requirements
- R1: Writes to the source register (cfg_sel 0) and destination register (cfg_sel 1) store the value with bit 0 forced to 0. The count register is cfg_sel 2 and the control word is cfg_sel 3.
- R2: A programmed count of 0 means SHORT_ZERO units (16384 by default) on channels 0, 1 and 2, and LONG_ZERO units (65536 by default) on channel 3.
- R3: Only a write that takes control bit 0 (enable) from 0 to 1 copies source, destination and count into the channel's working registers and arms it. Rewriting the control word while enable is already 1 leaves the working registers and any transfer in progress untouched.
- R4: The source mode is control bits 7:6 and the destination mode is bits 9:8. Mode 0 increments, 1 decrements, 2 holds the address fixed and 3 increments. The step is 4 bytes when control bit 4 is 1 (32-bit units) and 2 bytes otherwise.
- R5: The timing field is control bits 3:2. Code 0 starts the channel on its enable edge, 1 on a vblank pulse, 2 on an hblank pulse and 3 on a special_req pulse for that channel. Special timing on channel 0 never starts a transfer.
- R6: A 32-bit unit accesses its source and destination addresses rounded down to a multiple of 4, and the next working address steps from the rounded value.
- R7: When the last unit of a channel completes, a channel without repeat (control bit 5 = 0) clears its enable bit. A repeating channel stays enabled, reloads its count, reloads its destination only in destination mode 3, keeps its source, and waits for its next trigger.
- R8: If control bit 1 is set, irq[c] pulses for one cycle, in the cycle after the write handshake of channel c's last unit.
- R9: When several channels are pending at once, every unit of the lowest-numbered one is served before any unit of a higher-numbered one.
- R10: A lower-numbered channel that becomes pending while a higher-numbered one is running takes over after the current unit at most. The interrupted channel later resumes from its saved working addresses and count.
- R11: Each unit is a read followed by a write. A request and its address stay unchanged until mem_gnt. The write data equals the data read (its low 16 bits for a 16-bit unit). busy is high while a unit is in flight and low when the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel being written |
| cfg_sel | input | 2 | 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Register write value |
| hblank | input | 1 | Horizontal-blank trigger pulse |
| vblank | input | 1 | Vertical-blank trigger pulse |
| special_req | input | 4 | Per-channel special trigger pulses |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_wide | output | 1 | 1 for a 32-bit access, 0 for 16-bit |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | DW | Read data |
| busy | output | 1 | A unit is in flight |
| irq | output | 4 | Per-channel completion pulses |
| chan_on | output | 4 | Current enable bit of each channel |

## Verification
The bench goes after the points where a plausible mistake silently moves the wrong data.

- A rewrite of an already-enabled control word is checked against a changed source register. An engine that re-latches on level rather than on the edge would fetch from the new address.
- Odd and half-word-misaligned addresses are checked against the bit-0 clearing and 32-bit rounding rules. A design that misses either would issue addresses outside the expected stream.
- Zero counts are run on both a short channel and the long channel. Swapped limits would show up as extra or missing units.
- Repeats are run in reload and non-reload destination modes. Reloading the wrong address, or dropping enable, would break the second burst.
- A lower-numbered channel is triggered in the middle of another channel's burst. Ordering checks on the interleaved access log catch a missing pre-emption, or a resume that restarts instead of continuing.

// File: rtl/dma4_engine.sv
module dma4_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int SHORT_ZERO = 16384,
  parameter int LONG_ZERO = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_ch,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          hblank,
  input  logic          vblank,
  input  logic [3:0]    special_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic [3:0]    irq,
  output logic [3:0]    chan_on
);
  localparam int NCH = 4;
  localparam int ZW = $clog2(LONG_ZERO + 1);
  localparam int WCW = ((CW > ZW) ? CW : ZW) + 1;
  localparam int CTLW = 10;
  localparam int B_EN = 0, B_IRQ = 1, B_TIM = 2, B_WIDE = 4, B_RPT = 5, B_SM = 6, B_DM = 8;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t state;

  logic [AW-1:0]   src_r [NCH];
  logic [AW-1:0]   dst_r [NCH];
  logic [CW-1:0]   cnt_r [NCH];
  logic [CTLW-1:0] ctl_r [NCH];
  logic [AW-1:0]   wsrc [NCH];
  logic [AW-1:0]   wdst [NCH];
  logic [WCW-1:0]  wcnt [NCH];
  logic [NCH-1:0]  pend, trig_c, done_c, last_c, irq_q;
  logic [1:0]      cur, pick;
  logic [DW-1:0]   data_q;

  function automatic logic [WCW-1:0] units(input int c, input logic [CW-1:0] raw);
    if (raw != '0) return WCW'(raw);
    return (c == NCH - 1) ? WCW'(LONG_ZERO) : WCW'(SHORT_ZERO);
  endfunction

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic [1:0] m, input logic w);
    logic [AW-1:0] st;
    st = w ? AW'(4) : AW'(2);
    case (m)
      2'd1: return a - st;
      2'd2: return a;
      default: return a + st;
    endcase
  endfunction

  logic [CTLW-1:0] cur_ctl;
  logic            cur_wide;
  logic [AW-1:0]   eff_src, eff_dst;
  logic            unit_done;

  assign cur_ctl  = ctl_r[cur];
  assign cur_wide = cur_ctl[B_WIDE];
  assign eff_src  = cur_wide ? {wsrc[cur][AW-1:2], 2'b00} : wsrc[cur];
  assign eff_dst  = cur_wide ? {wdst[cur][AW-1:2], 2'b00} : wdst[cur];
  assign unit_done = (state == S_WR) && mem_gnt;

  assign mem_req   = (state != S_IDLE);
  assign mem_we    = (state == S_WR);
  assign mem_wide  = cur_wide;
  assign mem_addr  = (state == S_WR) ? eff_dst : eff_src;
  assign mem_wdata = data_q;
  assign busy      = mem_req;
  assign irq       = irq_q;

  always_comb begin
    pick = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (pend[c]) pick = 2'(c);
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      chan_on[c] = ctl_r[c][B_EN];
      done_c[c]  = unit_done && (cur == 2'(c));
      last_c[c]  = done_c[c] && (wcnt[c] == WCW'(1));
      trig_c[c]  = ctl_r[c][B_EN] &&
                   ((ctl_r[c][B_TIM+:2] == 2'd1 && vblank) ||
                    (ctl_r[c][B_TIM+:2] == 2'd2 && hblank) ||
                    (ctl_r[c][B_TIM+:2] == 2'd3 && special_req[c] && c != 0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur    <= '0;
      data_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (|pend) begin
          cur   <= pick;
          state <= S_RD;
        end
        S_RD: if (mem_gnt) begin
          data_q <= mem_rdata;
          state  <= S_WR;
        end
        default: if (mem_gnt) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        src_r[c] <= '0;
        dst_r[c] <= '0;
        cnt_r[c] <= '0;
        ctl_r[c] <= '0;
        wsrc[c]  <= '0;
        wdst[c]  <= '0;
        wcnt[c]  <= '0;
      end
      pend  <= '0;
      irq_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        irq_q[c] <= last_c[c] && ctl_r[c][B_IRQ];
        if (done_c[c]) begin
          wsrc[c] <= adv(eff_src, ctl_r[c][B_SM+:2], cur_wide);
          wdst[c] <= adv(eff_dst, ctl_r[c][B_DM+:2], cur_wide);
          wcnt[c] <= wcnt[c] - WCW'(1);
        end
        if (last_c[c]) begin
          pend[c] <= 1'b0;
          if (ctl_r[c][B_RPT]) begin
            wcnt[c] <= units(c, cnt_r[c]);
            if (ctl_r[c][B_DM+:2] == 2'd3) wdst[c] <= dst_r[c];
          end else begin
            ctl_r[c][B_EN] <= 1'b0;
          end
        end
        if (trig_c[c]) pend[c] <= 1'b1;
        if (cfg_we && cfg_ch == 2'(c)) begin
          case (cfg_sel)
            2'd0: src_r[c] <= {cfg_wdata[AW-1:1], 1'b0};
            2'd1: dst_r[c] <= {cfg_wdata[AW-1:1], 1'b0};
            2'd2: cnt_r[c] <= cfg_wdata[CW-1:0];
            default: begin
              ctl_r[c] <= cfg_wdata[CTLW-1:0];
              if (!ctl_r[c][B_EN] && cfg_wdata[B_EN]) begin
                wsrc[c] <= src_r[c];
                wdst[c] <= dst_r[c];
                wcnt[c] <= units(c, cnt_r[c]);
                pend[c] <= (cfg_wdata[B_TIM+:2] == 2'd0);
              end else if (!cfg_wdata[B_EN]) begin
                pend[c] <= 1'b0;
              end
            end
          endcase
        end
      end
    end
  end

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r11_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_gnt |=> mem_req && mem_we);

  a_r1_even_address: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  a_r8_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> $past(mem_req && mem_we && mem_gnt));

  a_r8_one_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));
endmodule

// File: tb/test_dma4_engine.sv
module test_dma4_engine;
  localparam int SZ = 24;
  localparam int LZ = 40;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_ch = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic hblank = 0, vblank = 0;
  logic [3:0] special_req = 0;
  logic mem_req, mem_we, mem_wide, mem_gnt = 0, busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] irq, chan_on;

  dma4_engine #(.SHORT_ZERO(SZ), .LONG_ZERO(LZ)) i_dma4_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hblank(hblank), .vblank(vblank), .special_req(special_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .busy(busy),
    .irq(irq), .chan_on(chan_on));

  function automatic logic [31:0] fdat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction
  assign mem_rdata = fdat(mem_addr);

  int checks = 0, fails = 0, cyc = 0, w3 = 0;
  string cur_req = "R11";
  logic [64:0] expq [4][$];
  logic [2:0] log_q [$];
  int irq_cnt [4] = '{0, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int mc;
    logic [64:0] e;
    logic ok;
    cyc++;
    mem_gnt = (cyc % 4) != 3;
    #1;
    for (int c = 0; c < 4; c++) if (irq[c]) irq_cnt[c]++;
    if (rst_n && mem_req && mem_gnt) begin
      mc = int'(mem_addr[25:24]);
      log_q.push_back({mem_we, mem_addr[25:24]});
      if (mem_we && mc == 3) w3++;
      if (expq[mc].size() == 0) begin
        chk(0, cur_req, {31'b0, mem_we, mem_addr}, 64'hFFFF_FFFF);
      end else begin
        e = expq[mc].pop_front();
        ok = (e[64] == mem_we) && (e[63:32] == mem_addr) &&
             (!mem_we || (mem_wide ? mem_wdata == e[31:0] : mem_wdata[15:0] == e[15:0]));
        chk(ok, cur_req, {mem_addr, mem_we ? mem_wdata : 32'h0}, {e[63:32], e[64] ? e[31:0] : 32'h0});
      end
    end
  end

  task automatic plan(input int c, inout logic [31:0] s, inout logic [31:0] d,
                      input int n, input bit wide, input int sm, input int dm);
    logic [31:0] es, ed, st;
    st = wide ? 32'd4 : 32'd2;
    for (int i = 0; i < n; i++) begin
      es = wide ? {s[31:2], 2'b00} : s;
      ed = wide ? {d[31:2], 2'b00} : d;
      expq[c].push_back({1'b0, es, 32'h0});
      expq[c].push_back({1'b1, ed, fdat(es)});
      s = (sm == 1) ? es - st : (sm == 2) ? es : es + st;
      d = (dm == 1) ? ed - st : (dm == 2) ? ed : ed + st;
    end
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit ir, input int tim, input bit wide,
                                      input bit rpt, input int sm, input int dm);
    return 32'(en) | (32'(ir) << 1) | (32'(tim) << 2) | (32'(wide) << 4) |
           (32'(rpt) << 5) | (32'(sm) << 6) | (32'(dm) << 8);
  endfunction

  task automatic wr(input int c, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(c); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_vb();
    @(negedge clk); vblank = 1; @(negedge clk); vblank = 0;
  endtask
  task automatic pulse_hb();
    @(negedge clk); hblank = 1; @(negedge clk); hblank = 0;
  endtask
  task automatic pulse_sp(input int c);
    @(negedge clk); special_req[c] = 1; @(negedge clk); special_req = 0;
  endtask

  task automatic drain();
    int n = 0;
    while ((expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size() != 0 || busy) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    for (int c = 0; c < 4; c++) chk(expq[c].size() == 0, cur_req, 64'(expq[c].size()), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] s, d, s2, d2;
    int l0, base, i0, f1, f2, last0, last1, last3, n3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_req && !busy && irq == 0 && chan_on == 0, "R11", {busy, mem_req, irq, chan_on}, 0);

    // R1, R4, R8: odd addresses, increment source, decrement destination, 16-bit
    cur_req = "R1,R4";
    s = 32'h1100_0100; d = 32'h2100_0200;
    plan(1, s, d, 4, 0, 0, 1);
    wr(1, 0, 32'h1100_0101); wr(1, 1, 32'h2100_0201); wr(1, 2, 4);
    wr(1, 3, ctl(1, 1, 0, 0, 0, 0, 1));
    drain();
    chk(chan_on[1] == 0, "R7", 64'(chan_on), 0);
    chk(irq_cnt[1] == 1, "R8", 64'(irq_cnt[1]), 1);

    // R6: 32-bit alignment with fixed source
    cur_req = "R6";
    s = 32'h1200_0106; d = 32'h2200_0302;
    plan(2, s, d, 3, 1, 2, 0);
    wr(2, 0, 32'h1200_0106); wr(2, 1, 32'h2200_0302); wr(2, 2, 3);
    wr(2, 3, ctl(1, 0, 0, 1, 0, 2, 0));
    drain();
    chk(irq_cnt[2] == 0, "R8", 64'(irq_cnt[2]), 0);

    // R2: zero count on a short channel and on channel 3
    cur_req = "R2";
    s = 32'h1000_0000; d = 32'h2000_0000;
    plan(0, s, d, SZ, 0, 0, 0);
    wr(0, 0, 32'h1000_0000); wr(0, 1, 32'h2000_0000); wr(0, 2, 0);
    wr(0, 3, ctl(1, 1, 0, 0, 0, 0, 0));
    drain();
    chk(irq_cnt[0] == 1, "R2", 64'(irq_cnt[0]), 1);
    s = 32'h1300_0000; d = 32'h2300_0000;
    plan(3, s, d, LZ, 1, 0, 0);
    wr(3, 0, 32'h1300_0000); wr(3, 1, 32'h2300_0000); wr(3, 2, 0);
    wr(3, 3, ctl(1, 1, 0, 1, 0, 0, 0));
    drain();
    chk(irq_cnt[3] == 1, "R2", 64'(irq_cnt[3]), 1);

    // R5, R7: hblank repeat with destination reload (mode 3)
    cur_req = "R5";
    wr(3, 0, 32'h1300_1000); wr(3, 1, 32'h2300_2000); wr(3, 2, 2);
    wr(3, 3, ctl(1, 1, 2, 0, 1, 0, 3));
    repeat (20) @(negedge clk);
    chk(!busy, "R5", 64'(busy), 0);
    pulse_vb();
    repeat (10) @(negedge clk);
    chk(!busy, "R5", 64'(busy), 0);
    s = 32'h1300_1000; d = 32'h2300_2000;
    plan(3, s, d, 2, 0, 0, 3);
    pulse_hb();
    drain();
    chk(chan_on[3] == 1, "R7", 64'(chan_on), 8);
    chk(irq_cnt[3] == 2, "R8", 64'(irq_cnt[3]), 2);
    cur_req = "R7";
    d = 32'h2300_2000;
    plan(3, s, d, 2, 0, 0, 3);
    pulse_hb();
    drain();
    wr(3, 3, 0);

    // R7: repeat in destination mode 0 keeps advancing destination
    s2 = 32'h1200_1000; d2 = 32'h2200_1000;
    wr(2, 0, s2); wr(2, 1, d2); wr(2, 2, 1);
    wr(2, 3, ctl(1, 0, 2, 1, 1, 0, 0));
    plan(2, s2, d2, 1, 1, 0, 0);
    pulse_hb();
    drain();
    plan(2, s2, d2, 1, 1, 0, 0);
    pulse_hb();
    drain();
    chk(chan_on[2] == 1, "R7", 64'(chan_on), 4);
    wr(2, 3, 0);

    // R5: special on channel 0 ignored, on channel 1 honoured
    cur_req = "R5";
    wr(0, 0, 32'h1000_3000); wr(0, 1, 32'h2000_3000); wr(0, 2, 1);
    wr(0, 3, ctl(1, 0, 3, 0, 0, 0, 0));
    pulse_sp(0);
    repeat (20) @(negedge clk);
    chk(chan_on[0] == 1 && !busy, "R5", {busy, chan_on}, 1);
    wr(0, 3, 0);
    s = 32'h1100_3000; d = 32'h2100_3000;
    plan(1, s, d, 1, 0, 0, 0);
    wr(1, 0, 32'h1100_3000); wr(1, 1, 32'h2100_3000); wr(1, 2, 1);
    wr(1, 3, ctl(1, 0, 3, 0, 0, 0, 0));
    pulse_sp(1);
    drain();
    chk(chan_on[1] == 0, "R5", 64'(chan_on), 0);

    // R3: rewrite of an enabled control word does not re-latch
    cur_req = "R3";
    wr(2, 0, 32'h1200_4000); wr(2, 1, 32'h2200_4000); wr(2, 2, 2);
    wr(2, 3, ctl(1, 0, 1, 0, 0, 0, 0));
    wr(2, 0, 32'h1200_8000); wr(2, 2, 5);
    wr(2, 3, ctl(1, 0, 1, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    chk(!busy, "R3", 64'(busy), 0);
    s = 32'h1200_4000; d = 32'h2200_4000;
    plan(2, s, d, 2, 0, 0, 0);
    pulse_vb();
    drain();

    // R9: fixed priority on a shared trigger
    cur_req = "R9";
    wr(2, 0, 32'h1200_6000); wr(2, 1, 32'h2200_6000); wr(2, 2, 3);
    wr(2, 3, ctl(1, 0, 1, 0, 0, 0, 0));
    wr(0, 0, 32'h1000_6000); wr(0, 1, 32'h2000_6000); wr(0, 2, 3);
    wr(0, 3, ctl(1, 0, 1, 0, 0, 0, 0));
    s = 32'h1200_6000; d = 32'h2200_6000; plan(2, s, d, 3, 0, 0, 0);
    s = 32'h1000_6000; d = 32'h2000_6000; plan(0, s, d, 3, 0, 0, 0);
    l0 = log_q.size();
    pulse_vb();
    drain();
    last0 = -1; f2 = 1 << 30;
    for (int i = l0; i < log_q.size(); i++) begin
      if (log_q[i][1:0] == 2'd0) last0 = i;
      if (log_q[i][1:0] == 2'd2 && f2 > i) f2 = i;
    end
    chk(last0 >= 0 && last0 < f2, "R9", 64'(last0), 64'(f2));

    // R10: pre-emption of channel 3 by channel 1
    cur_req = "R10";
    wr(1, 0, 32'h1100_7000); wr(1, 1, 32'h2100_7000); wr(1, 2, 2);
    wr(1, 3, ctl(1, 1, 1, 0, 0, 0, 0));
    s = 32'h1100_7000; d = 32'h2100_7000; plan(1, s, d, 2, 0, 0, 0);
    s = 32'h1300_7000; d = 32'h2300_7000; plan(3, s, d, 10, 0, 0, 0);
    wr(3, 0, 32'h1300_7000); wr(3, 1, 32'h2300_7000); wr(3, 2, 10);
    base = w3;
    wr(3, 3, ctl(1, 0, 0, 0, 0, 0, 0));
    i0 = 0;
    while (w3 - base < 3 && i0 < 500) begin @(negedge clk); i0++; end
    l0 = log_q.size();
    pulse_vb();
    drain();
    f1 = 1 << 30; last1 = -1; last3 = -1;
    for (int i = l0; i < log_q.size(); i++) begin
      if (log_q[i][1:0] == 2'd1) begin
        if (f1 > i) f1 = i;
        last1 = i;
      end
      if (log_q[i][1:0] == 2'd3) last3 = i;
    end
    n3 = 0;
    for (int i = l0; i < log_q.size() && i < f1; i++)
      if (log_q[i] == 3'b111) n3++;
    chk(n3 <= 1, "R10", 64'(n3), 1);
    chk(last1 >= 0 && last1 < last3, "R10", 64'(last1), 64'(last3));
    chk(chan_on == 0 && !busy, "R11", {busy, chan_on}, 0);

    finish_run();
  end
endmodule